// File: doc/BRIEF.md
# Scanline Interrupt and Multiplier Register Unit

This block is a small processor-visible register unit. It holds a scanline compare value, an interrupt enable and a pending flag. A read of the status register returns the pending flag and clears it. The block also holds two unsigned multiplicands. Their full-width product can be read back as a low byte and a high byte, with no wait after the write.

The video side sends a one-cycle pulse when each scanline is reached, together with the line number and an in-frame level. The interrupt output is high while an event is pending and the enable is set. Any read that the block does not decode returns the open-bus byte, which is supplied on an input. A quiet-read input lets a debugger read the status without side effects.

Top module: `line_irq_mult_unit`

## Requirements
- R1: After reset the compare value is 0, the enable is 0, the pending flag is 0, the irq output is low and both multiplicands are 0xFF. The product therefore reads 0x01 at the low byte and 0xFE at the high byte.
- R2: A write to address 0x5203 stores the 8-bit compare value. A scanline pulse whose line number equals that value sets the pending flag at the next clock edge.
- R3: While the compare value is 0, no scanline pulse sets the pending flag.
- R4: A scanline pulse whose line number differs from the compare value leaves the pending flag unchanged.
- R5: A write to 0x5204 stores data bit 7 as the enable and ignores bits 6:0. The irq output is high exactly when the pending flag and the enable are both 1.
- R6: A read of 0x5204 returns the status byte. Bit 7 is the pending flag, bit 6 is the in-frame input, and bits 5:0 are zero.
- R7: A read of 0x5204 with quiet low clears the pending flag at the clock edge that ends the read, which also drops the irq output.
- R8: A read of 0x5204 with quiet high leaves the pending flag and the irq output unchanged.
- R9: Writes to 0x5205 and 0x5206 store the two multiplicands. In the cycle after the write, reads of 0x5205 and 0x5206 return product bits 7:0 and 15:8.
- R10: A read of any address other than 0x5204, 0x5205 or 0x5206 returns the open-bus input. This includes the write-only address 0x5203.
- R11: A matching scanline pulse in the same cycle as a clearing status read leaves the pending flag set. The read returns the value the flag had before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rd_quiet | input | 1 | When high, a read has no side effect |
| bus_rdata | output | 8 | Read data, combinational from the address |
| open_bus | input | 8 | Byte returned for reads that are not decoded |
| line_tick | input | 1 | One-cycle pulse when a scanline is reached |
| line_num | input | 8 | Number of the scanline that was reached |
| in_frame | input | 1 | High while the video side is rendering |
| irq_out | output | 1 | Active-high interrupt request |

## Verification
The bench targets these corner cases:
- A compare value of zero. A design that skipped the zero guard would raise a spurious pending flag on line 0.
- A line number one below the compare value. A sloppy comparison would fire a line early.
- An enable write with only bits 6:0 set. A design that latched more than bit 7 would raise the interrupt.
- A quiet status read. A design that ignored the quiet input would lose the pending event.
- A clearing read in the same cycle as a new match. If clear won over set, that interrupt would be lost.
- Products that carry across the byte boundary. These show up a wrong split between the low and high bytes.
- Reads of the write-only compare address. A design that decoded it would leak register state in place of the open-bus byte.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

   // register select produced by the address decoder
   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_CMP  = 3'd1,
      SEL_CTL  = 3'd2,
      SEL_MA   = 3'd3,
      SEL_MB   = 3'd4
   } reg_sel_e;

   // offsets of the registers from the block base address
   localparam int unsigned OFS_CMP = 0;
   localparam int unsigned OFS_CTL = 1;
   localparam int unsigned OFS_MA  = 2;
   localparam int unsigned OFS_MB  = 3;

   // multiplier implementation variants
   localparam int unsigned MUL_OPERATOR = 0;
   localparam int unsigned MUL_SHIFTADD = 1;

endpackage

// File: rtl/lirq_decode.sv
module lirq_decode
   import lirq_pkg::*;
#(
   parameter int unsigned        AW   = 16,
   parameter logic [AW-1:0]      BASE = 16'h5203
)(
   input  logic [AW-1:0] addr,
   output reg_sel_e      sel
);

   localparam logic [AW-1:0] A_CMP = BASE + AW'(OFS_CMP);
   localparam logic [AW-1:0] A_CTL = BASE + AW'(OFS_CTL);
   localparam logic [AW-1:0] A_MA  = BASE + AW'(OFS_MA);
   localparam logic [AW-1:0] A_MB  = BASE + AW'(OFS_MB);

   always_comb begin
      if (addr == A_CMP)      sel = SEL_CMP;
      else if (addr == A_CTL) sel = SEL_CTL;
      else if (addr == A_MA)  sel = SEL_MA;
      else if (addr == A_MB)  sel = SEL_MB;
      else                    sel = SEL_NONE;
   end

endmodule

// File: rtl/lirq_irq_core.sv
module lirq_irq_core #(
   parameter int unsigned LW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cmp,
   input  logic [LW-1:0] cmp_wdata,
   input  logic          wr_en,
   input  logic          en_wbit,
   input  logic          rd_clr,
   input  logic          line_tick,
   input  logic [LW-1:0] line_num,
   output logic          pend,
   output logic          irq_out
);

   logic [LW-1:0] cmp_q;
   logic          en_q;
   logic          pend_q;
   logic          hit;

   // a match needs a nonzero compare value
   assign hit = line_tick && (cmp_q != '0) && (line_num == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '0;
         en_q  <= 1'b0;
      end else begin
         if (wr_cmp) cmp_q <= cmp_wdata;
         if (wr_en)  en_q  <= en_wbit;
      end
   end

   // set has priority over the read-clear so no event is lost
   always_ff @(posedge clk) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (hit)    pend_q <= 1'b1;
      else if (rd_clr) pend_q <= 1'b0;
   end

   assign pend    = pend_q;
   assign irq_out = pend_q & en_q;

   // R2: a match sets the flag at the next edge
   a_r2_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && cmp_q != '0 && line_num == cmp_q) |=> pend_q);

   // R3: zero compare never raises the flag
   a_r3_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && cmp_q == '0) |=> !pend_q);

   // R7: a clearing read with no match drops the flag
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !(line_tick && cmp_q != '0 && line_num == cmp_q)) |=> !pend_q);

   // R4: a non-matching pulse cannot raise the flag
   a_r4_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && line_num != cmp_q) |=> !pend_q);

endmodule

// File: rtl/lirq_mult.sv
module lirq_mult
   import lirq_pkg::*;
#(
   parameter int unsigned DW   = 8,
   parameter int unsigned IMPL = MUL_OPERATOR
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_a,
   input  logic            wr_b,
   input  logic [DW-1:0]   wdata,
   output logic [2*DW-1:0] prod
);

   localparam int unsigned PW = 2 * DW;

   logic [DW-1:0] a_q;
   logic [DW-1:0] b_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '1;
         b_q <= '1;
      end else begin
         if (wr_a) a_q <= wdata;
         if (wr_b) b_q <= wdata;
      end
   end

   generate
      if (IMPL == MUL_OPERATOR) begin : g_op
         assign prod = PW'(a_q) * PW'(b_q);
      end else if (IMPL == MUL_SHIFTADD) begin : g_sa
         logic [PW-1:0] acc;
         always_comb begin
            acc = '0;
            for (int i = 0; i < DW; i++) begin
               if (b_q[i]) acc = acc + (PW'(a_q) << i);
            end
         end
         assign prod = acc;
      end else begin : g_bad
         $error("lirq_mult: unknown IMPL");
         assign prod = '0;
      end
   endgenerate

   // R9: the product only moves when an operand is written
   a_r9_prod_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_a && !wr_b) |=> $stable(prod));

endmodule

// File: rtl/line_irq_mult_unit.sv
module line_irq_mult_unit
   import lirq_pkg::*;
#(
   parameter int unsigned   AW       = 16,
   parameter int unsigned   DW       = 8,
   parameter logic [AW-1:0] BASE     = 16'h5203,
   parameter int unsigned   MUL_IMPL = MUL_OPERATOR
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic          bus_rd_quiet,
   output logic [DW-1:0] bus_rdata,
   input  logic [DW-1:0] open_bus,
   input  logic          line_tick,
   input  logic [DW-1:0] line_num,
   input  logic          in_frame,
   output logic          irq_out
);

   localparam int unsigned PW        = 2 * DW;
   localparam int unsigned PEND_BIT  = DW - 1;
   localparam int unsigned FRAME_BIT = DW - 2;

   generate
      if (DW < 8) begin : g_chk_dw
         $error("line_irq_mult_unit: DW must be at least 8");
      end
      if (AW < 16) begin : g_chk_aw
         $error("line_irq_mult_unit: AW must be at least 16");
      end
   endgenerate

   reg_sel_e      sel;
   logic          pend;
   logic          rd_clr;
   logic [PW-1:0] prod;
   logic [DW-1:0] status;

   lirq_decode #(.AW(AW), .BASE(BASE)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign rd_clr = bus_rd && !bus_rd_quiet && (sel == SEL_CTL);

   lirq_irq_core #(.LW(DW)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cmp    (bus_wr && sel == SEL_CMP),
      .cmp_wdata (bus_wdata),
      .wr_en     (bus_wr && sel == SEL_CTL),
      .en_wbit   (bus_wdata[PEND_BIT]),
      .rd_clr    (rd_clr),
      .line_tick (line_tick),
      .line_num  (line_num),
      .pend      (pend),
      .irq_out   (irq_out)
   );

   lirq_mult #(.DW(DW), .IMPL(MUL_IMPL)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_a  (bus_wr && sel == SEL_MA),
      .wr_b  (bus_wr && sel == SEL_MB),
      .wdata (bus_wdata),
      .prod  (prod)
   );

   always_comb begin
      status            = '0;
      status[PEND_BIT]  = pend;
      status[FRAME_BIT] = in_frame;
   end

   always_comb begin
      unique case (sel)
         SEL_CTL: bus_rdata = status;
         SEL_MA:  bus_rdata = prod[DW-1:0];
         SEL_MB:  bus_rdata = prod[PW-1:DW];
         default: bus_rdata = open_bus;
      endcase
   end

   // R8: a quiet status read keeps the pending flag
   a_r8_quiet_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_rd_quiet && sel == SEL_CTL && pend) |=> pend);

   // R5: the interrupt never rises without a pending event
   a_r5_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> pend);

   // R10: undecoded reads pass the open-bus byte
   a_r10_open_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE || sel == SEL_CMP) |-> (bus_rdata == open_bus));

endmodule

// File: tb/sim_line_irq_mult_unit.sv
module sim_line_irq_mult_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_rd_quiet = 1'b0;
   logic [7:0]  bus_rdata;
   logic [7:0]  open_bus = 8'h00;
   logic        line_tick = 1'b0;
   logic [7:0]  line_num = '0;
   logic        in_frame = 1'b0;
   logic        irq_out;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   line_irq_mult_unit u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rd_quiet(bus_rd_quiet),
      .bus_rdata(bus_rdata), .open_bus(open_bus), .line_tick(line_tick),
      .line_num(line_num), .in_frame(in_frame), .irq_out(irq_out)
   );

   // {multiplicand A, multiplicand B, expected 16-bit product}
   localparam logic [31:0] MVEC [8] = '{
      32'hFFFF_FE01, 32'h1234_03A8, 32'h00AB_0000, 32'h8002_0100,
      32'h0F11_00FF, 32'hC864_4E20, 32'h01FF_00FF, 32'h7F81_3FFF
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // drives a read for one cycle, samples mid-cycle
   task automatic rd(input logic [15:0] a, input logic quiet, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_rd_quiet = quiet;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_rd_quiet = 1'b0;
   endtask

   task automatic tick(input logic [7:0] n);
      @(negedge clk);
      line_tick = 1'b1; line_num = n;
      @(negedge clk);
      line_tick = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1 chk("R1 irq", {7'd0, irq_out}, 8'h00);
      rd(16'h5205, 1'b0, v); chk("R1 prod lo", v, 8'h01);
      rd(16'h5206, 1'b0, v); chk("R1 prod hi", v, 8'hFE);
      rd(16'h5204, 1'b1, v); chk("R1 R6 status", v, 8'h00);

      // R9 product table
      foreach (MVEC[i]) begin
         wr(16'h5205, MVEC[i][31:24]);
         wr(16'h5206, MVEC[i][23:16]);
         rd(16'h5205, 1'b0, v); chk("R9 lo", v, MVEC[i][7:0]);
         rd(16'h5206, 1'b0, v); chk("R9 hi", v, MVEC[i][15:8]);
      end

      // R10 open bus
      open_bus = 8'h5A;
      rd(16'h5203, 1'b0, v); chk("R10 5203", v, 8'h5A);
      rd(16'h5207, 1'b0, v); chk("R10 5207", v, 8'h5A);
      rd(16'h4000, 1'b0, v); chk("R10 4000", v, 8'h5A);

      // R3 zero compare
      tick(8'h00);
      rd(16'h5204, 1'b1, v); chk("R3 no pend", v, 8'h00);

      // R4 miss, R2 match, R6 in-frame bit
      wr(16'h5203, 8'h20);
      in_frame = 1'b1;
      tick(8'h1F);
      rd(16'h5204, 1'b1, v); chk("R4 miss", v, 8'h40);
      tick(8'h20);
      rd(16'h5204, 1'b1, v); chk("R2 R6 hit", v, 8'hC0);
      chk("R5 disabled", {7'd0, irq_out}, 8'h00);

      // R5 only bit 7 enables
      wr(16'h5204, 8'h7F);
      chk("R5 low bits", {7'd0, irq_out}, 8'h00);
      wr(16'h5204, 8'h80);
      chk("R5 enabled", {7'd0, irq_out}, 8'h01);

      // R8 quiet read
      rd(16'h5204, 1'b1, v); chk("R8 value", v, 8'hC0);
      chk("R8 irq kept", {7'd0, irq_out}, 8'h01);

      // R7 clearing read
      rd(16'h5204, 1'b0, v); chk("R7 value", v, 8'hC0);
      chk("R7 irq dropped", {7'd0, irq_out}, 8'h00);
      rd(16'h5204, 1'b1, v); chk("R7 cleared", v, 8'h40);

      // R11 set beats clear
      tick(8'h20);
      @(negedge clk);
      line_tick = 1'b1; line_num = 8'h20;
      bus_addr = 16'h5204; bus_rd = 1'b1; bus_rd_quiet = 1'b0;
      #2 v = bus_rdata;
      @(negedge clk);
      line_tick = 1'b0; bus_rd = 1'b0;
      chk("R11 read value", v, 8'hC0);
      chk("R11 irq kept", {7'd0, irq_out}, 8'h01);

      // R5 disabling masks a pending event
      wr(16'h5204, 8'h00);
      chk("R5 masked", {7'd0, irq_out}, 8'h00);
      rd(16'h5204, 1'b1, v); chk("R5 still pending", v, 8'hC0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule